// File: doc/BRIEF.md
# Deadtime-Gated Pulse Counter Channel

This block is one counting channel for a multichannel scaler. It counts single-cycle input pulses into a wrapping counter. When deadtime gating is on, each pulse that gets counted opens a dead window. Pulses that arrive inside that window are dropped. When the window expires, the channel re-arms by itself. The length of the window is built from two settings shared by all channels: a step count and a step-width code. Each channel keeps its own timer.

The window lasts (steps + 1) step widths. A step width is 3, 6, 12 or 24 base ticks, and one base tick is TICK_DIV clock cycles (40 ns at the intended clock). The settings are taken in only while gating is off. A rewrite therefore follows the order disable, write, enable. Besides the count, the channel gives a sticky overflow flag, a dead indicator and a gated copy of the input, one cycle behind it.

Top module: `dtc_channel`

## Requirements
- R1: After reset, count_o is 0 and overflow_o, dead_o and hit_o are all 0.
- R2: While dt_en_i is 0, every cycle with pulse_i high adds 1 to count_o in the next cycle, with hit_o high in that same cycle, and dead_o stays 0.
- R3: A pulse counted at count value 2^CNT_W-1 wraps count_o to 0 and sets overflow_o. overflow_o then stays 1 until reset.
- R4: While dt_en_i is 1, a pulse sampled with dead_o low is counted and raises dead_o in the next cycle.
- R5: A pulse sampled while dead_o and dt_en_i are both 1 is not counted, and hit_o stays 0 in the following cycle.
- R6: dead_o stays high for exactly (steps+1) x stepwidth x TICK_DIV cycles. A pulse in the first cycle after it falls is counted and opens a new window.
- R7: Step-width code dt_width_i maps as follows: 0 = 3 base ticks (120 ns), 1 = 6 (240 ns), 2 = 12 (480 ns), 3 = 24 (960 ns). dt_steps_i ranges from 0 to 63.
- R8: The step count and step-width code are captured on every cycle in which dt_en_i is 0. Changes made while dt_en_i is 1 have no effect until gating is disabled and enabled again.
- R9: Dropping dt_en_i ends any dead window, so dead_o is 0 in the next cycle, and following pulses count as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_i | input | 1 | Single-cycle count pulse |
| dt_en_i | input | 1 | Deadtime gating enable |
| dt_steps_i | input | STEP_W | Shared step count, 0 to 63 |
| dt_width_i | input | 2 | Shared step-width code |
| count_o | output | CNT_W | Count value |
| overflow_o | output | 1 | Sticky wrap flag |
| dead_o | output | 1 | Channel is in its dead window |
| hit_o | output | 1 | Gated copy of the input, one cycle late |

## Verification
The bench builds the channel with CNT_W = 8 and TICK_DIV = 2. With an 8-bit counter, the wrap and the sticky overflow are reached in a few hundred pulses. With the short base tick, even the longest window (64 steps of 24 ticks, 3072 cycles) can be measured cycle by cycle. A table of step and width settings is swept across every width code and the step-count extremes. For each setting, the bench checks that a pulse in the last dead cycle is dropped and that a pulse in the first free cycle is counted. Directed tests cover settings rewritten while gating is enabled, disabling gating inside a window, and reset after overflow.

// File: rtl/dtc_pkg.sv
// Package: shared constants and the step-width decoder for the deadtime
// gated counter channel.
// Assumes: the step-width code is 2 bits and each code doubles the width.
package dtc_pkg;

    // Base ticks in the shortest step.
    localparam int BASE_STEP_TICKS = 3;
    // Base ticks in the longest step (code 3).
    localparam int MAX_STEP_TICKS  = BASE_STEP_TICKS << 3;

    // Clock cycles in one step for a given width code.
    function automatic int step_cycles(input logic [1:0] code, input int tick_div);
        return (BASE_STEP_TICKS << code) * tick_div;
    endfunction

endpackage

// File: rtl/dtc_preload.sv
// Module: holds the shared deadtime settings that the channel's timer
// reloads from.
// Assumes: the settings may only change while gating is off. They are
// therefore followed while disabled and frozen while enabled.
module dtc_preload #(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [STEP_W-1:0] steps_i,
    input  logic [1:0]        width_i,
    output logic [STEP_W-1:0] steps_o,
    output logic [1:0]        width_o
);

    // Track the settings while gating is off; freeze them while on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_o <= '0;
            width_o <= '0;
        end else if (!en_i) begin
            steps_o <= steps_i;
            width_o <= width_i;
        end
    end

endmodule

// File: rtl/dtc_dead_timer.sv
// Module: per-channel dead-window timer. It is armed by a counted pulse and
// runs (steps+1) steps, each of step_cycles(width) clock cycles.
// Assumes: arm_i is only raised while the timer is idle and enabled.
module dtc_dead_timer
    import dtc_pkg::*;
#(
    parameter int STEP_W   = 6,
    parameter int TICK_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              arm_i,
    input  logic [STEP_W-1:0] steps_i,
    input  logic [1:0]        width_i,
    output logic              dead_o
);

    localparam int MAX_CYC = MAX_STEP_TICKS * TICK_DIV;
    localparam int SUB_W   = $clog2(MAX_CYC);

    logic [STEP_W-1:0] step_left;
    logic [SUB_W-1:0]  sub_left;
    logic [SUB_W-1:0]  sub_reload;

    // Cycle count of one step, less one, for the selected width.
    always_comb begin
        sub_reload = SUB_W'(step_cycles(width_i, TICK_DIV) - 1);
    end

    // Count down cycles within each step, then steps, until the window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dead_o    <= 1'b0;
            step_left <= '0;
            sub_left  <= '0;
        end else if (!en_i) begin
            dead_o    <= 1'b0;
            step_left <= '0;
            sub_left  <= '0;
        end else if (arm_i) begin
            dead_o    <= 1'b1;
            step_left <= steps_i;
            sub_left  <= sub_reload;
        end else if (dead_o) begin
            if (sub_left == '0) begin
                if (step_left == '0) begin
                    dead_o <= 1'b0;
                end else begin
                    step_left <= step_left - 1'b1;
                    sub_left  <= sub_reload;
                end
            end else begin
                sub_left <= sub_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dtc_counter.sv
// Module: wrapping event counter with a sticky overflow flag and a
// registered hit strobe.
// Assumes: inc_i is a single-cycle accept; the count wraps at 2^CNT_W.
module dtc_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             overflow_o,
    output logic             hit_o
);

    logic at_top;

    // The next increment wraps the count.
    always_comb begin
        at_top = &count_o;
    end

    // Advance the count and latch a wrap into the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o    <= '0;
            overflow_o <= 1'b0;
            hit_o      <= 1'b0;
        end else begin
            hit_o <= inc_i;
            if (inc_i) begin
                count_o <= count_o + CNT_W'(1);
                if (at_top) begin
                    overflow_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dtc_channel.sv
// Module: one deadtime-gated counting channel (top). A counted pulse opens
// a dead window in which further pulses are dropped; the channel re-arms
// by itself when the window expires.
// Assumes: pulse_i is synchronous and one cycle wide; the shared settings
// are rewritten only while dt_en_i is low.
module dtc_channel #(
    parameter int CNT_W    = 20,
    parameter int STEP_W   = 6,
    parameter int TICK_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  logic              dt_en_i,
    input  logic [STEP_W-1:0] dt_steps_i,
    input  logic [1:0]        dt_width_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              overflow_o,
    output logic              dead_o,
    output logic              hit_o
);

    logic [STEP_W-1:0] pl_steps;
    logic [1:0]        pl_width;
    logic              accept;
    logic              arm;

    // Drop pulses only while gating is on and the window is open.
    always_comb begin
        accept = pulse_i & ~(dt_en_i & dead_o);
        arm    = accept & dt_en_i;
    end

    dtc_preload #(.STEP_W(STEP_W)) u_preload (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (dt_en_i),
        .steps_i (dt_steps_i),
        .width_i (dt_width_i),
        .steps_o (pl_steps),
        .width_o (pl_width)
    );

    dtc_dead_timer #(.STEP_W(STEP_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (dt_en_i),
        .arm_i   (arm),
        .steps_i (pl_steps),
        .width_i (pl_width),
        .dead_o  (dead_o)
    );

    dtc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (accept),
        .count_o    (count_o),
        .overflow_o (overflow_o),
        .hit_o      (hit_o)
    );

endmodule

// File: rtl/dtc_channel_chk.sv
// Module: property checker for the deadtime-gated channel, bound to the top.
// Assumes: observes ports only.
module dtc_channel_chk #(
    parameter int CNT_W  = 20,
    parameter int STEP_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pulse_i,
    input logic              dt_en_i,
    input logic [STEP_W-1:0] dt_steps_i,
    input logic [1:0]        dt_width_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              overflow_o,
    input logic              dead_o,
    input logic              hit_o
);

    AST_FREE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dt_en_i && pulse_i) |=> (hit_o && !dead_o)); // R2

    AST_HIT_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (count_o == CNT_W'($past(count_o) + 1'b1))); // R2

    AST_NO_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> $stable(count_o)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R3

    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && count_o == '0) |-> overflow_o); // R3

    AST_ARM_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_en_i && pulse_i && !dead_o) |=> (dead_o && hit_o)); // R4

    AST_DEAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_en_i && dead_o) |=> !hit_o); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !dt_en_i |=> !dead_o); // R9

endmodule

bind dtc_channel dtc_channel_chk #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_i    (pulse_i),
    .dt_en_i    (dt_en_i),
    .dt_steps_i (dt_steps_i),
    .dt_width_i (dt_width_i),
    .count_o    (count_o),
    .overflow_o (overflow_o),
    .dead_o     (dead_o),
    .hit_o      (hit_o)
);

// File: tb/dtc_channel_tb.sv
module dtc_channel_tb;

    localparam int CNT_W = 8;
    localparam int STEP_W = 6;
    localparam int TDIV = 2;
    localparam int NS_PER_TICK = 40;

    typedef struct packed {
        int steps;
        int code;
        int dead_ns;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{0,  0, 120},
        '{9,  0, 1200},
        '{2,  1, 720},
        '{1,  2, 960},
        '{0,  3, 960},
        '{63, 0, 7680},
        '{5,  3, 5760},
        '{63, 3, 61440}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_i = 1'b0;
    logic             dt_en_i = 1'b0;
    logic [STEP_W-1:0] dt_steps_i = '0;
    logic [1:0]       dt_width_i = '0;
    logic [CNT_W-1:0] count_o;
    logic             overflow_o;
    logic             dead_o;
    logic             hit_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dtc_channel #(.CNT_W(CNT_W), .STEP_W(STEP_W), .TICK_DIV(TDIV)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_i    (pulse_i),
        .dt_en_i    (dt_en_i),
        .dt_steps_i (dt_steps_i),
        .dt_width_i (dt_width_i),
        .count_o    (count_o),
        .overflow_o (overflow_o),
        .dead_o     (dead_o),
        .hit_o      (hit_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic pulse_once();
        pulse_i = 1'b1;
        @(negedge clk);
        pulse_i = 1'b0;
    endtask

    // Count the cycles dead_o stays high, starting in a cycle where it is high.
    task automatic measure_dead(output int n);
        n = 1;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (dead_o) n++;
            else break;
        end
    endtask

    task automatic run_vec(input int s, input int w, input int ns);
        logic [CNT_W-1:0] c0;
        int d;
        int bad;
        d = ns / NS_PER_TICK * TDIV;
        dt_en_i = 1'b0;
        dt_steps_i = STEP_W'(s);
        dt_width_i = 2'(w);
        repeat (2) @(negedge clk);
        dt_en_i = 1'b1;
        @(negedge clk);
        c0 = count_o;
        pulse_once();
        chk(dead_o && hit_o && count_o == CNT_W'(c0 + 1), "R4 accept opens window",
            int'(count_o), int'(CNT_W'(c0 + 1)));
        bad = 0;
        for (int k = 1; k < d; k++) begin
            @(negedge clk);
            if (!dead_o) bad++;
        end
        chk(bad == 0 && dead_o, "R7 window held for width code", bad, 0);
        // Pulse in the last dead cycle: must be dropped.
        pulse_once();
        chk(!dead_o, "R6 window length", int'(dead_o), 0);
        chk(!hit_o && count_o == CNT_W'(c0 + 1), "R5 pulse in dead window dropped",
            int'(count_o), int'(CNT_W'(c0 + 1)));
        // Pulse in the first free cycle: must be counted.
        pulse_once();
        chk(hit_o && dead_o && count_o == CNT_W'(c0 + 2), "R6 pulse after expiry counted",
            int'(count_o), int'(CNT_W'(c0 + 2)));
        dt_en_i = 1'b0;
        @(negedge clk);
        chk(!dead_o, "R9 disable ends window", int'(dead_o), 0);
        pulse_once();
        chk(hit_o && count_o == CNT_W'(c0 + 3), "R9 pulse counts after disable",
            int'(count_o), int'(CNT_W'(c0 + 3)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] c0;
        int n;
        int exp_n;
        repeat (4) @(negedge clk);
        chk(count_o == '0 && !overflow_o && !dead_o && !hit_o, "R1 reset state",
            int'(count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i].steps, VECS[i].code, VECS[i].dead_ns);
        end

        // R2: burst of back-to-back pulses with gating off.
        dt_en_i = 1'b0;
        @(negedge clk);
        c0 = count_o;
        pulse_i = 1'b1;
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (dead_o) n++;
        end
        pulse_i = 1'b0;
        chk(hit_o && n == 0 && count_o == CNT_W'(c0 + 10), "R2 free burst counted",
            int'(count_o), int'(CNT_W'(c0 + 10)));
        @(negedge clk);
        chk(!hit_o && count_o == CNT_W'(c0 + 10), "R2 idle holds count",
            int'(count_o), int'(CNT_W'(c0 + 10)));

        // R8: settings changed while enabled are ignored.
        dt_steps_i = '0;
        dt_width_i = 2'd0;
        repeat (2) @(negedge clk);
        dt_en_i = 1'b1;
        dt_steps_i = 6'd63;
        dt_width_i = 2'd3;
        @(negedge clk);
        pulse_once();
        measure_dead(n);
        exp_n = 120 / NS_PER_TICK * TDIV;
        chk(n == exp_n, "R8 change while enabled ignored", n, exp_n);
        dt_en_i = 1'b0;
        repeat (2) @(negedge clk);
        dt_en_i = 1'b1;
        @(negedge clk);
        pulse_once();
        measure_dead(n);
        exp_n = 61440 / NS_PER_TICK * TDIV;
        chk(n == exp_n, "R8 new setting after re-enable", n, exp_n);

        // R3: wrap and sticky overflow.
        dt_en_i = 1'b0;
        @(negedge clk);
        chk(!overflow_o, "R3 no overflow before wrap", int'(overflow_o), 0);
        n = (1 << CNT_W) - 1 - int'(count_o);
        if (n > 0) begin
            pulse_i = 1'b1;
            repeat (n) @(negedge clk);
            pulse_i = 1'b0;
        end
        chk(&count_o && !overflow_o, "R3 count at top", int'(count_o), (1 << CNT_W) - 1);
        pulse_once();
        chk(count_o == '0 && overflow_o, "R3 wrap sets overflow", int'(count_o), 0);
        pulse_i = 1'b1;
        repeat (5) @(negedge clk);
        pulse_i = 1'b0;
        @(negedge clk);
        chk(count_o == CNT_W'(5) && overflow_o, "R3 overflow sticky", int'(overflow_o), 1);

        // R1: reset after activity.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(count_o == '0 && !overflow_o && !dead_o && !hit_o, "R1 reset clears state",
            int'(count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule